// File: doc/BRIEF.md
# CAN Line Driver Transmit Control

This block is the digital core that sits between a CAN protocol controller and the analog stage of a high-speed CAN line driver. It picks one of three operating modes from a silent-select input and an optional enable input. It turns the controller's transmit data into a single command for the dominant driver. It passes the analog comparator's bus indication back to the controller as receive data, and it can tri-state that output through an output-enable.

Two protections can cut the transmitter off. The first is a dominant time-out. A falling edge on transmit data arms it, and a rising edge clears it. If transmit data stays low for longer than the limit, the driver is forced recessive, so a stuck controller cannot block the bus. The second is a thermal latch. It takes effect when the over-temperature flag asserts, and it releases only after the flag has dropped and transmit data is high.

Both protections act on the driver alone. Reception and mode decode keep working while either one holds the driver off. The asynchronous pin inputs pass through two-flop synchronizers. Their reset values model the levels an unconnected pin settles to.

Top module: `cantx_ctrl`

## Requirements
- R1: In normal mode (enable high, silent low), `drvDominant` is 1 while the synchronized transmit data is 0 and 0 while it is 1. Pin changes reach the output after two clock edges.
- R2: While `rxdOe` is 1, `rxdOut` equals the inverse of `busDomIn` with no clock delay. This also holds when the bus is made dominant by another node.
- R3: In silent mode (enable high, silent high), `drvDominant` is 0 whatever the transmit data. `rxdOe` stays 1.
- R4: In off mode (enable low), `drvDominant` is 0 and `rxdOe` is 0, whatever the silent and transmit inputs.
- R5: When transmit data goes low and stays low, `drvDominant` is 1 for exactly TIMEOUT_CYC+1 cycles. It then falls to 0, and `timeoutActive` rises to 1 in that same cycle.
- R6: A rising edge on transmit data clears `timeoutActive` on the third clock edge after the pin rises. A low pulse shorter than the limit never sets it.
- R7: One edge after `overTempIn` is 1, `thermalActive` is 1 and `drvDominant` is 0. Mode decode and receive data keep working.
- R8: `thermalActive` stays 1 while `overTempIn` is 1, or while the synchronized transmit data is 0. It clears on the third edge after the transmit pin rises, provided `overTempIn` is already low.
- R9: The synchronizer reset values are parameters that model the levels of unconnected pins. The defaults are transmit high, silent low and enable low. During reset the outputs are `drvDominant`=0, `rxdOe`=0, `timeoutActive`=0 and `thermalActive`=0.
- R10: With HAS_ENABLE=0 the enable input is ignored and treated as high. With enable held low the block then works in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txdIn | input | 1 | Transmit data from the controller, 0 = dominant (asynchronous) |
| silentIn | input | 1 | Silent-mode select (asynchronous) |
| enableIn | input | 1 | Transceiver enable, low = off mode (asynchronous) |
| busDomIn | input | 1 | Comparator output, 1 = bus dominant |
| overTempIn | input | 1 | Over-temperature flag from the sensor |
| drvDominant | output | 1 | Command for the analog driver to drive dominant |
| rxdOut | output | 1 | Receive data to the controller, 0 = bus dominant |
| rxdOe | output | 1 | Output-enable of rxdOut, 0 = high impedance |
| timeoutActive | output | 1 | Dominant time-out has disabled the transmitter |
| thermalActive | output | 1 | Thermal latch has disabled the transmitter |

## Verification
The hardest state to reach is the thermal latch held after the temperature has already recovered. To get there, the over-temperature flag must be raised while transmit data is low, and then dropped before transmit data rises. The bench builds that order on purpose. It also checks that the latch holds until the third edge after the pin rises. The time-out limit is shortened through its parameter so that expiry can be reached in a few tens of cycles. The bench samples the cycle just before expiry and the cycle of expiry. A second instance, built without the enable pin, shows that a low enable is ignored.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SILENT = 2'd1,
    MODE_NORMAL = 2'd2
  } mode_e;

  // strobes from control to the time-out counter
  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } tmrStrobe_t;

endpackage

// File: rtl/cantx_datapath.sv
module cantx_datapath #(
  parameter int unsigned TIMEOUT_CYC = 16000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          TXD_IDLE    = 1'b1,
  parameter bit          SILENT_IDLE = 1'b0,
  parameter bit          ENABLE_IDLE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txdIn,
  input  logic                   silentIn,
  input  logic                   enableIn,
  input  cantx_pkg::tmrStrobe_t  strobe,
  output logic                   txdSync,
  output logic                   txdPrev,
  output logic                   silentSync,
  output logic                   enableSync,
  output logic                   timeoutHit
);

  localparam int unsigned PIN_CNT = 3;
  localparam int unsigned CNT_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CYC);
  localparam logic [PIN_CNT-1:0] PIN_IDLE = {ENABLE_IDLE, SILENT_IDLE, TXD_IDLE};

  logic [PIN_CNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_CNT-1:0] pinRaw;
  logic [CNT_W-1:0]   domCnt;

  assign pinRaw = {enableIn, silentIn, txdIn};

  // synchronizer chain, reset to the unconnected-pin levels
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[s] <= PIN_IDLE;
      end else begin
        syncStage[s] <= (s == 0) ? pinRaw : syncStage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign txdSync    = syncStage[SYNC_STAGES-1][0];
  assign silentSync = syncStage[SYNC_STAGES-1][1];
  assign enableSync = syncStage[SYNC_STAGES-1][2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txdPrev <= TXD_IDLE;
    end else begin
      txdPrev <= txdSync;
    end
  end

  // saturating dominant-duration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt <= '0;
    end else if (strobe.cntClear) begin
      domCnt <= '0;
    end else if (strobe.cntRun && (domCnt != CNT_LIMIT)) begin
      domCnt <= domCnt + 1'b1;
    end
  end

  assign timeoutHit = (domCnt == CNT_LIMIT);

endmodule

// File: rtl/cantx_control.sv
module cantx_control #(
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txdSync,
  input  logic                   txdPrev,
  input  logic                   silentSync,
  input  logic                   enableSync,
  input  logic                   timeoutHit,
  input  logic                   overTempIn,
  input  logic                   busDomIn,
  output cantx_pkg::tmrStrobe_t  strobe,
  output cantx_pkg::mode_e       modeSel,
  output logic                   drvDominant,
  output logic                   rxdOut,
  output logic                   rxdOe,
  output logic                   timeoutActive,
  output logic                   thermalActive
);

  import cantx_pkg::*;

  logic txFall;
  logic txRise;
  logic armed;
  logic enEff;
  logic thermOff;

  assign txFall = txdPrev & ~txdSync;
  assign txRise = ~txdPrev & txdSync;

  if (HAS_ENABLE) begin : g_en
    assign enEff = enableSync;
  end else begin : g_noen
    assign enEff = 1'b1;
  end

  always_comb begin
    if (!enEff) begin
      modeSel = MODE_OFF;
    end else if (silentSync) begin
      modeSel = MODE_SILENT;
    end else begin
      modeSel = MODE_NORMAL;
    end
  end

  // armed on a falling edge, disarmed on a rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (txFall) begin
      armed <= 1'b1;
    end else if (txRise) begin
      armed <= 1'b0;
    end
  end

  assign strobe.cntClear = txFall | txRise;
  assign strobe.cntRun   = armed & ~txdSync;

  // thermal latch: releases only when cool and transmit data high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermOff <= 1'b0;
    end else if (overTempIn) begin
      thermOff <= 1'b1;
    end else if (txdSync) begin
      thermOff <= 1'b0;
    end
  end

  assign drvDominant   = (modeSel == MODE_NORMAL) & ~txdSync & ~timeoutHit & ~thermOff;
  assign rxdOe         = (modeSel != MODE_OFF);
  assign rxdOut        = ~busDomIn;
  assign timeoutActive = timeoutHit;
  assign thermalActive = thermOff;

endmodule

// File: rtl/cantx_ctrl.sv
module cantx_ctrl #(
  parameter int unsigned TIMEOUT_CYC = 16000,
  parameter bit          HAS_ENABLE  = 1'b1,
  parameter bit          TXD_IDLE    = 1'b1,
  parameter bit          SILENT_IDLE = 1'b0,
  parameter bit          ENABLE_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic silentIn,
  input  logic enableIn,
  input  logic busDomIn,
  input  logic overTempIn,
  output logic drvDominant,
  output logic rxdOut,
  output logic rxdOe,
  output logic timeoutActive,
  output logic thermalActive
);

  cantx_pkg::tmrStrobe_t tmrStrobe;
  cantx_pkg::mode_e      modeSel;
  logic txdSync;
  logic txdPrev;
  logic silentSync;
  logic enableSync;
  logic timeoutHit;

  cantx_datapath #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (2),
    .TXD_IDLE    (TXD_IDLE),
    .SILENT_IDLE (SILENT_IDLE),
    .ENABLE_IDLE (ENABLE_IDLE)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .txdIn      (txdIn),
    .silentIn   (silentIn),
    .enableIn   (enableIn),
    .strobe     (tmrStrobe),
    .txdSync    (txdSync),
    .txdPrev    (txdPrev),
    .silentSync (silentSync),
    .enableSync (enableSync),
    .timeoutHit (timeoutHit)
  );

  cantx_control #(
    .HAS_ENABLE (HAS_ENABLE)
  ) i_control (
    .clk           (clk),
    .rstN          (rstN),
    .txdSync       (txdSync),
    .txdPrev       (txdPrev),
    .silentSync    (silentSync),
    .enableSync    (enableSync),
    .timeoutHit    (timeoutHit),
    .overTempIn    (overTempIn),
    .busDomIn      (busDomIn),
    .strobe        (tmrStrobe),
    .modeSel       (modeSel),
    .drvDominant   (drvDominant),
    .rxdOut        (rxdOut),
    .rxdOe         (rxdOe),
    .timeoutActive (timeoutActive),
    .thermalActive (thermalActive)
  );

endmodule

// File: rtl/cantx_ctrl_chk.sv
module cantx_ctrl_chk (
  input logic             clk,
  input logic             rstN,
  input logic             busDomIn,
  input logic             overTempIn,
  input logic             drvDominant,
  input logic             rxdOut,
  input logic             rxdOe,
  input logic             timeoutActive,
  input logic             thermalActive,
  input logic             txdSync,
  input cantx_pkg::mode_e modeSel
);

  // R3
  nonnormal_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != cantx_pkg::MODE_NORMAL) |-> !drvDominant);

  // R4
  off_no_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == cantx_pkg::MODE_OFF) |-> !rxdOe);

  // R2
  rx_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxdOe |-> (rxdOut == !busDomIn));

  // R5
  timeout_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutActive |-> !drvDominant);

  // R6
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutActive && txdSync) |=> !timeoutActive);

  // R7
  thermal_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    thermalActive |-> !drvDominant);

  // R7
  thermal_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    overTempIn |=> thermalActive);

  // R8
  thermal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thermalActive && !txdSync) |=> thermalActive);

endmodule

bind cantx_ctrl cantx_ctrl_chk i_cantx_ctrl_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busDomIn      (busDomIn),
  .overTempIn    (overTempIn),
  .drvDominant   (drvDominant),
  .rxdOut        (rxdOut),
  .rxdOe         (rxdOe),
  .timeoutActive (timeoutActive),
  .thermalActive (thermalActive),
  .txdSync       (txdSync),
  .modeSel       (modeSel)
);

// File: tb/test_cantx_ctrl.sv
module test_cantx_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 20;
  localparam int NVEC       = 9;

  // {silent, enable, txd, busDom, expDrv, expRxd, expOe}
  localparam logic [6:0] VECS [NVEC] = '{
    7'b0101_101,  // normal, own dominant
    7'b0110_011,  // normal, recessive
    7'b1100_011,  // silent, txd low ignored
    7'b1101_001,  // silent, other node dominant
    7'b0111_001,  // normal, other node dominant
    7'b0001_000,  // off
    7'b1010_000,  // off, silent set
    7'b0100_111,  // normal, own dominant, comparator low
    7'b0110_011   // normal, recessive
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b1;
  logic silentIn = 1'b0;
  logic enableIn = 1'b0;
  logic busDomIn = 1'b0;
  logic overTempIn = 1'b0;
  logic drvDominant, rxdOut, rxdOe, timeoutActive, thermalActive;
  logic drvB, rxdB, oeB, toB, thB;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cantx_ctrl #(.TIMEOUT_CYC(TMO), .HAS_ENABLE(1'b1)) i_cantx_ctrl (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .silentIn(silentIn), .enableIn(enableIn),
    .busDomIn(busDomIn), .overTempIn(overTempIn), .drvDominant(drvDominant),
    .rxdOut(rxdOut), .rxdOe(rxdOe), .timeoutActive(timeoutActive),
    .thermalActive(thermalActive)
  );

  // variant without enable pin, enable input held low
  cantx_ctrl #(.TIMEOUT_CYC(TMO), .HAS_ENABLE(1'b0)) i_cantx_ctrl_noen (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .silentIn(silentIn), .enableIn(1'b0),
    .busDomIn(busDomIn), .overTempIn(overTempIn), .drvDominant(drvB),
    .rxdOut(rxdB), .rxdOe(oeB), .timeoutActive(toB), .thermalActive(thB)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string req;
    // R9 reset state
    waitNeg(2);
    check("R9", "drvDominant in reset", drvDominant, 1'b0);
    check("R9", "rxdOe in reset", rxdOe, 1'b0);
    check("R9", "timeoutActive in reset", timeoutActive, 1'b0);
    check("R9", "thermalActive in reset", thermalActive, 1'b0);
    rstN = 1'b1;
    waitNeg(4);
    check("R9", "rxdOe with enable at idle level", rxdOe, 1'b0);
    check("R10", "rxdOe without enable pin", oeB, 1'b1);

    // mode/receive table
    for (int v = 0; v < NVEC; v++) begin
      {silentIn, enableIn, txdIn, busDomIn} = VECS[v][6:3];
      waitNeg(4);
      req = !VECS[v][5] ? "R4" : (VECS[v][6] ? "R3" : "R1");
      check(req, $sformatf("drvDominant row %0d", v), drvDominant, VECS[v][2]);
      check(req, $sformatf("rxdOe row %0d", v), rxdOe, VECS[v][0]);
      if (VECS[v][0]) check("R2", $sformatf("rxdOut row %0d", v), rxdOut, VECS[v][1]);
    end

    // R1 two-edge latency
    txdIn = 1'b1; waitNeg(4);
    txdIn = 1'b0;
    waitNeg(1);
    check("R1", "drv after one edge", drvDominant, 1'b0);
    waitNeg(1);
    check("R1", "drv after two edges", drvDominant, 1'b1);
    check("R10", "no-enable variant drives", drvB, 1'b1);

    // R5 time-out expiry
    waitNeg(TMO);  // j = TMO+2
    check("R5", "drv just before limit", drvDominant, 1'b1);
    check("R5", "timeoutActive before limit", timeoutActive, 1'b0);
    waitNeg(1);    // j = TMO+3
    check("R5", "drv at limit", drvDominant, 1'b0);
    check("R5", "timeoutActive at limit", timeoutActive, 1'b1);
    waitNeg(2);
    busDomIn = 1'b1; #1;
    check("R2", "rxdOut during time-out", rxdOut, 1'b0);
    busDomIn = 1'b0;

    // R6 release by rising edge
    txdIn = 1'b1;
    waitNeg(2);
    check("R6", "timeoutActive in rise cycle", timeoutActive, 1'b1);
    waitNeg(1);
    check("R6", "timeoutActive cleared", timeoutActive, 1'b0);
    // short low pulse never trips
    txdIn = 1'b0; waitNeg(TMO - 5);
    txdIn = 1'b1; waitNeg(10);
    check("R6", "short pulse timeoutActive", timeoutActive, 1'b0);
    // new low after clear drives again
    txdIn = 1'b0; waitNeg(3);
    check("R6", "drive restored after clear", drvDominant, 1'b1);

    // R7 thermal set while driving
    overTempIn = 1'b1;
    waitNeg(1);
    check("R7", "thermalActive set", thermalActive, 1'b1);
    check("R7", "drv off under thermal", drvDominant, 1'b0);
    busDomIn = 1'b1; #1;
    check("R7", "rxdOut still follows bus", rxdOut, 1'b0);
    check("R7", "rxdOe still on", rxdOe, 1'b1);
    busDomIn = 1'b0;

    // R8 cool but txd still low: hold
    overTempIn = 1'b0;
    waitNeg(3);
    check("R8", "latch holds with txd low", thermalActive, 1'b1);
    txdIn = 1'b1;
    waitNeg(2);
    check("R8", "latch holds in rise cycle", thermalActive, 1'b1);
    waitNeg(1);
    check("R8", "latch released", thermalActive, 1'b0);

    // R8 hot with txd high: hold
    overTempIn = 1'b1; waitNeg(4);
    check("R8", "latch holds while hot, txd high", thermalActive, 1'b1);
    overTempIn = 1'b0; waitNeg(1);
    check("R8", "latch clears once cool, txd high", thermalActive, 1'b0);
    txdIn = 1'b0; waitNeg(3);
    check("R7", "drive resumes after thermal", drvDominant, 1'b1);
    txdIn = 1'b1; waitNeg(4);

    // R10 enable low ignored by variant, honoured by main
    enableIn = 1'b0; waitNeg(4);
    check("R4", "main rxdOe with enable low", rxdOe, 1'b0);
    check("R10", "variant rxdOe with enable low", oeB, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule